// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This unit supplies the fetch address for a small single-cycle 8-bit controller. It holds a 10-bit program counter. The counter is split into two pages of 512 words, and the page is picked by a page-select bit that comes from the status register. Each instruction cycle, the decoder presents one control class: sequential, jump, call, return-with-literal or low-byte write. The unit forms the next counter value from that class, the instruction's address field, the page-select bit and the data written to the counter's low byte.

Calls and low-byte writes always clear counter bit 8. A subroutine entry or computed jump can therefore reach only the lower half of a page. A two-level return stack holds the return addresses. It has no overflow or underflow indication. On overflow the oldest entry is lost, and when the stack runs dry, level 2 keeps supplying its address. In a return cycle the unit also presents the instruction's literal on a load port, with a strobe, so that an external accumulator can capture it.

Top module: `pcu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the counter is set to 0x3FF and both stack levels are set to zero. `rst` is synchronous and active high.
- R2: Class code 0 (sequential) advances the counter by one. The count wraps from 0x3FF to 0x000 and does not depend on `page_sel`.
- R3: Class code 1 (jump) loads counter bits 8:0 from `addr_field` and counter bit 9 from `page_sel`.
- R4: Class code 2 (call) loads counter bits 7:0 from `addr_field[7:0]`, clears bit 8 and takes bit 9 from `page_sel`.
- R5: Class code 4 (low-byte write) loads counter bits 7:0 from `pcl_wdata`, clears bit 8 and takes bit 9 from `page_sel`.
- R6: A call moves level 1 into level 2 and writes the current counter plus one into level 1. The entry is zero-extended to 12 bits.
- R7: Class code 3 (return) loads the counter from the low 10 bits of level 1 and copies level 2 into level 1. Level 2 keeps its value.
- R8: After more than two nested calls, only the two latest return addresses remain. Each return beyond the second resumes at the address held in level 2.
- R9: `wload_en` is high in exactly the cycles whose class is return. In those cycles `wload_data` equals `addr_field[7:0]`.
- R10: `fetch_addr` is the registered counter, and `pcl_out` is its bits 7:0.
- R11: Class codes 5, 6 and 7 act as sequential and leave the stack untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction per cycle |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 3 | Decoded control class of the current instruction |
| addr_field | input | 9 | Address or literal field of the instruction word |
| page_sel | input | 1 | Page-select bit from the status register |
| pcl_wdata | input | 8 | Value written to the counter low byte |
| fetch_addr | output | 10 | Current program counter (fetch address) |
| pcl_out | output | 8 | Counter low byte |
| wload_data | output | 8 | Literal for the accumulator on return |
| wload_en | output | 1 | Accumulator load strobe |

## Verification
A return cycle does two things in the same cycle: the stack shifts and the counter redirects, and the literal is offered on the accumulator port. The bench drives return classes and checks the strobe and literal before the edge. After the edge it checks the restored address. A second collision arises when a call pushes while level 1 is moving into level 2. The bench provokes it with three nested calls. A run of three returns then shows that the oldest address was lost and that level 2 keeps being reused.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_JMP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_PCLW = 3'd4
    } pcu_op_e;
endpackage

// File: rtl/pcu_next.sv
module pcu_next #(
    parameter int PC_W = 10
) (
    input  logic [2:0]      op_i,
    input  logic [PC_W-1:0] pc_q_i,
    input  logic [PC_W-2:0] addr_i,
    input  logic            page_i,
    input  logic [PC_W-3:0] wdata_i,
    input  logic [PC_W-1:0] stk_top_i,
    output logic [PC_W-1:0] pc_d_o,
    output logic [PC_W-1:0] push_val_o,
    output logic            push_o,
    output logic            pop_o
);
    import pcu_pkg::*;
    localparam int LOW_W = PC_W - 2;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            push;
        logic            pop;
    } nxt_t;

    nxt_t nxt_d;
    logic [PC_W-1:0] pc_inc;

    always_comb begin
        pc_inc      = pc_q_i + PC_W'(1);
        nxt_d.pc    = pc_inc;
        nxt_d.push  = 1'b0;
        nxt_d.pop   = 1'b0;
        case (op_i)
            OP_JMP:  nxt_d.pc = {page_i, addr_i};
            OP_CALL: begin
                nxt_d.pc   = {page_i, 1'b0, addr_i[LOW_W-1:0]};
                nxt_d.push = 1'b1;
            end
            OP_RET: begin
                nxt_d.pc  = stk_top_i;
                nxt_d.pop = 1'b1;
            end
            OP_PCLW: nxt_d.pc = {page_i, 1'b0, wdata_i};
            default: nxt_d.pc = pc_inc;
        endcase
    end

    assign pc_d_o     = nxt_d.pc;
    assign push_o     = nxt_d.push;
    assign pop_o      = nxt_d.pop;
    assign push_val_o = pc_inc;
endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
    parameter int PC_W  = 10,
    parameter int STK_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] push_val_i,
    output logic [PC_W-1:0] top_o
);
    localparam int PAD_W = STK_W - PC_W;

    typedef struct packed {
        logic [STK_W-1:0] lvl1;
        logic [STK_W-1:0] lvl2;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push_i) begin
            stk_d.lvl2 = stk_q.lvl1;
            stk_d.lvl1 = {{PAD_W{1'b0}}, push_val_i};
        end else if (pop_i) begin
            stk_d.lvl1 = stk_q.lvl2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stk_q <= '0;
        else     stk_q <= stk_d;
    end

    assign top_o = stk_q.lvl1[PC_W-1:0];

    // R6: pushed entries never carry bits above the counter width
    a_r6_zero_ext: assert property (@(posedge clk) disable iff (rst)
        stk_q.lvl1[STK_W-1:PC_W] == '0);
    // R6: a push moves the old level 1 into level 2
    a_r6_push_shift: assert property (@(posedge clk) disable iff (rst)
        push_i |=> stk_q.lvl2 == $past(stk_q.lvl1));
    // R7: a pop leaves level 2 untouched
    a_r7_pop_keeps_lvl2: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> $stable(stk_q.lvl2));
endmodule

// File: rtl/pcu_core.sv
module pcu_core #(
    parameter int PC_W  = 10,
    parameter int STK_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      op_class,
    input  logic [PC_W-2:0] addr_field,
    input  logic            page_sel,
    input  logic [PC_W-3:0] pcl_wdata,
    output logic [PC_W-1:0] fetch_addr,
    output logic [PC_W-3:0] pcl_out,
    output logic [PC_W-3:0] wload_data,
    output logic            wload_en
);
    import pcu_pkg::*;
    localparam int LOW_W = PC_W - 2;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } core_t;

    core_t core_d, core_q;
    logic [PC_W-1:0] pc_next, push_val, stk_top;
    logic            push, pop;

    pcu_next #(.PC_W(PC_W)) i_next (
        .op_i       (op_class),
        .pc_q_i     (core_q.pc),
        .addr_i     (addr_field),
        .page_i     (page_sel),
        .wdata_i    (pcl_wdata),
        .stk_top_i  (stk_top),
        .pc_d_o     (pc_next),
        .push_val_o (push_val),
        .push_o     (push),
        .pop_o      (pop)
    );

    pcu_stack #(.PC_W(PC_W), .STK_W(STK_W)) i_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (push_val),
        .top_o      (stk_top)
    );

    always_comb begin
        core_d.pc = pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) core_q.pc <= '1;
        else     core_q <= core_d;
    end

    assign fetch_addr = core_q.pc;
    assign pcl_out    = core_q.pc[LOW_W-1:0];
    assign wload_en   = pop;
    assign wload_data = addr_field[LOW_W-1:0];

    // R1: counter leaves reset at the last word of the last page
    a_r1_reset_vector: assert property (@(posedge clk)
        $past(rst) |-> fetch_addr == '1);
    // R2: sequential step adds one
    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (op_class == OP_SEQ) |=> fetch_addr == $past(fetch_addr) + PC_W'(1));
    // R4: call target always lies in the lower half of a page
    a_r4_call_bit8: assert property (@(posedge clk) disable iff (rst)
        (op_class == OP_CALL) |=> fetch_addr[PC_W-2] == 1'b0);
    // R5: low-byte write also clears bit 8
    a_r5_pclw_bit8: assert property (@(posedge clk) disable iff (rst)
        (op_class == OP_PCLW) |=> fetch_addr[PC_W-2] == 1'b0);
    // R9: strobe only in return cycles
    a_r9_strobe: assert property (@(posedge clk) disable iff (rst)
        wload_en == (op_class == OP_RET));
    // R11: never push and pop in one cycle
    a_r11_one_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push, pop}));
endmodule

// File: tb/test_pcu_core.sv
module test_pcu_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_class;
    logic [8:0] addr_field;
    logic       page_sel;
    logic [7:0] pcl_wdata;
    logic [9:0] fetch_addr;
    logic [7:0] pcl_out;
    logic [7:0] wload_data;
    logic       wload_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcu_core i_pcu_core (
        .clk(clk), .rst(rst), .op_class(op_class), .addr_field(addr_field),
        .page_sel(page_sel), .pcl_wdata(pcl_wdata), .fetch_addr(fetch_addr),
        .pcl_out(pcl_out), .wload_data(wload_data), .wload_en(wload_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, register at posedge, come back at negedge
    task automatic step(input logic [2:0] op, input logic [8:0] a,
                        input logic pg, input logic [7:0] wd);
        op_class = op; addr_field = a; page_sel = pg; pcl_wdata = wd;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3'd0, 9'h0, 1'b1, 8'h0);
        step(3'd0, 9'h0, 1'b1, 8'h0);
        rst = 1'b0;
    endtask

    task automatic t_reset_and_wrap();
        do_reset();
        chk("R1 reset vector", fetch_addr, 10'h3FF);
        step(3'd0, 9'h0, 1'b1, 8'h0);
        chk("R2 wrap to zero ignoring page", fetch_addr, 10'h000);
        chk("R10 low byte", pcl_out, 8'h00);
    endtask

    task automatic t_jump_and_seq();
        step(3'd1, 9'h1AB, 1'b1, 8'h0);
        chk("R3 jump page1", fetch_addr, 10'h3AB);
        chk("R10 low byte after jump", pcl_out, 8'hAB);
        step(3'd1, 9'h1FF, 1'b0, 8'h0);
        chk("R3 jump page0", fetch_addr, 10'h1FF);
        step(3'd0, 9'h0, 1'b0, 8'h0);
        chk("R2 crosses page boundary", fetch_addr, 10'h200);
    endtask

    task automatic t_call_ret();
        step(3'd2, 9'h1CD, 1'b0, 8'h0);
        chk("R4 call clears bit8", fetch_addr, 10'h0CD);
        op_class = 3'd3; addr_field = 9'h05A; page_sel = 1'b1; pcl_wdata = 8'h0;
        #1;
        chk("R9 strobe in return", wload_en, 1);
        chk("R9 literal in return", wload_data, 8'h5A);
        @(posedge clk); @(negedge clk);
        chk("R6 R7 return to pushed address", fetch_addr, 10'h201);
        op_class = 3'd0; #1;
        chk("R9 strobe idle otherwise", wload_en, 0);
    endtask

    task automatic t_pcl_write();
        step(3'd4, 9'h1FF, 1'b1, 8'h77);
        chk("R5 low-byte write", fetch_addr, 10'h277);
        chk("R10 low byte after write", pcl_out, 8'h77);
    endtask

    task automatic t_nested();
        step(3'd1, 9'h000, 1'b0, 8'h0);
        step(3'd2, 9'h010, 1'b0, 8'h0);
        step(3'd2, 9'h020, 1'b0, 8'h0);
        step(3'd2, 9'h030, 1'b0, 8'h0);
        chk("R4 third call target", fetch_addr, 10'h030);
        step(3'd3, 9'h0, 1'b0, 8'h0);
        chk("R8 first return", fetch_addr, 10'h021);
        step(3'd3, 9'h0, 1'b0, 8'h0);
        chk("R8 second return", fetch_addr, 10'h011);
        step(3'd3, 9'h0, 1'b0, 8'h0);
        chk("R8 extra return reuses level2", fetch_addr, 10'h011);
    endtask

    task automatic t_undefined_codes();
        step(3'd1, 9'h040, 1'b0, 8'h0);
        step(3'd5, 9'h1FF, 1'b1, 8'hFF);
        chk("R11 code5 sequential", fetch_addr, 10'h041);
        step(3'd6, 9'h1FF, 1'b1, 8'hFF);
        step(3'd7, 9'h1FF, 1'b1, 8'hFF);
        chk("R11 code6/7 sequential", fetch_addr, 10'h043);
        step(3'd3, 9'h0, 1'b0, 8'h0);
        chk("R11 stack untouched", fetch_addr, 10'h011);
    endtask

    task automatic t_reset_clears_stack();
        step(3'd2, 9'h0AA, 1'b1, 8'h0);
        do_reset();
        step(3'd1, 9'h155, 1'b0, 8'h0);
        step(3'd3, 9'h0, 1'b0, 8'h0);
        chk("R1 stack cleared by reset", fetch_addr, 10'h000);
    endtask

    initial begin
        op_class = 3'd0; addr_field = '0; page_sel = 1'b0; pcl_wdata = '0;
        rst = 1'b1;
        @(negedge clk);
        t_reset_and_wrap();
        t_jump_and_seq();
        t_call_ret();
        t_pcl_write();
        t_nested();
        t_undefined_codes();
        t_reset_clears_stack();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule